// File: doc/BRIEF.md
# Two-Wire Register Write Slave

This block is the slave end of a two-wire serial control bus. It receives a bus clock and a data line. It answers on the data line only by pulling it low, so the line stays open-drain. A transaction begins with a start condition. Next comes an address byte that carries a 7-bit device address and a direction bit. After that comes a register-address byte, then one or more data bytes. The block acknowledges every byte it accepts. When a data byte's acknowledge ends, the block raises a one-cycle write strobe with the register address and data, and stores the byte in an internal register file. A read port on that file gives the rest of the chip access to the stored settings.

Both bus lines are brought into the system clock domain through two-flop synchronizers, and all bus events are decoded from the synchronized copies. A state machine steps through the transaction. Its states are `S_IDLE` (wait for start), `S_DEV` (shift the device byte), `S_DEV_ACK`, `S_REG` (shift the register byte), `S_REG_ACK`, `S_DAT` (shift a data byte), `S_DAT_ACK` and `S_HOLD` (write done, wait for stop or start). Its transitions are:
- start → `S_DEV`
- 8th bit of a matching write address → `S_DEV_ACK`, any other address byte → `S_IDLE`
- end of acknowledge → the next byte state
- end of data acknowledge → `S_DAT` when continuous mode is on, otherwise `S_HOLD`
- stop anywhere, or start outside `S_IDLE`/`S_HOLD` → `S_IDLE`

Top module: `twr_slave`

## Requirements
- R1: After reset the data line is not pulled, the write strobe is low, and every register-file entry reads 0.
- R2: When the first byte after a start carries the configured device address in bits 7..1 and a 0 (write) in bit 0, the block pulls the data line low through the ninth bus clock high phase.
- R3: An address byte whose upper 7 bits differ from the configured address is not acknowledged. No later byte of that transaction is acknowledged, and nothing is written.
- R4: A matching address with bit 0 set (read) is not acknowledged. The block goes idle and writes nothing.
- R5: The byte after the address is the register address. It is acknowledged, and only its bits 6..0 are used; bit 7 is ignored.
- R6: A data byte is acknowledged. After the falling edge of its acknowledge clock, `wr_stb_o` pulses for exactly one cycle with the register address and the data, and the register file then holds the data at that address.
- R7: With `cont_en_i` low, a data byte that follows the first data byte in the same transaction is not acknowledged and is not written.
- R8: With `cont_en_i` high, each further data byte is acknowledged and written to the next register address. The address wraps from 127 to 0.
- R9: A stop condition in the middle of a byte returns the block to idle. The partial byte is not written.
- R10: A start condition in the middle of a transfer abandons it and returns the block to idle. The bytes that follow are not acknowledged until a stop and a new start.
- R11: The acknowledge pull is applied and released only while the bus clock is low. It is released after the falling edge of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain enable) |
| dev_addr_i | input | 7 | Configured device address |
| cont_en_i | input | 1 | 1 = accept consecutive data bytes at incrementing addresses |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 7 | Register address of the write |
| wr_data_o | output | 8 | Data of the write |
| rd_addr_i | input | 7 | Register-file read address |
| rd_data_o | output | 8 | Register-file contents at `rd_addr_i` |

## Verification
The in-RTL assertions check the following on every cycle:
- the acknowledge pull is present only in an acknowledge state, and switches on only after the bus clock is seen low
- a stop always leads to idle, and a misplaced start always leads to idle
- the write strobe is a single-cycle pulse that follows a data acknowledge

Only the bench's bus scenarios can show the rest: address match and mismatch, the read refusal, the ignored bit 7 of the register byte, single-byte and continuous writes with wrap-around, and partial bytes cut off by a stop or a start. The bench does this by comparing every strobe against a queue of expected writes and by reading back the register file.

// File: rtl/twr_pkg.sv
package twr_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_REG,
        S_REG_ACK,
        S_DAT,
        S_DAT_ACK,
        S_HOLD
    } twr_state_e;
endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic sync_o,
    output logic prev_o
);
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {(STAGES+1){RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twr_slave.sv
module twr_slave
    import twr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic [ADDR_W-1:0] dev_addr_i,
    input  logic              cont_en_i,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, scl_p, sda_s, sda_p;

    twr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .sync_o(scl_s), .prev_o(scl_p)
    );
    twr_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .sync_o(sda_s), .prev_o(sda_p)
    );

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

    twr_state_e state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-2:0] shift_q;
    logic [BYTE_W-1:0] byte_in;
    logic              bit_last, in_shift, in_ack;
    logic              ack_q, wr_stb_q;
    logic [ADDR_W-1:0] ptr_q, wr_addr_q;
    logic [BYTE_W-1:0] dat_q, wr_data_q;
    logic              commit;

    assign byte_in  = {shift_q, sda_s};
    assign bit_last = (bit_cnt_q == LAST_BIT);
    assign in_shift = (state_q == S_DEV) || (state_q == S_REG) || (state_q == S_DAT);
    assign in_ack   = (state_q == S_DEV_ACK) || (state_q == S_REG_ACK) || (state_q == S_DAT_ACK);
    assign commit   = (state_q == S_DAT_ACK) && scl_fall && ack_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_det) state_d = S_DEV;
            S_DEV:     if (scl_rise && bit_last)
                           state_d = (byte_in[BYTE_W-1:1] == dev_addr_i && !byte_in[0])
                                     ? S_DEV_ACK : S_IDLE;
            S_DEV_ACK: if (scl_fall && ack_q) state_d = S_REG;
            S_REG:     if (scl_rise && bit_last) state_d = S_REG_ACK;
            S_REG_ACK: if (scl_fall && ack_q) state_d = S_DAT;
            S_DAT:     if (scl_rise && bit_last) state_d = S_DAT_ACK;
            S_DAT_ACK: if (scl_fall && ack_q) state_d = cont_en_i ? S_DAT : S_HOLD;
            S_HOLD:    if (start_det) state_d = S_DEV;
            default:   state_d = S_IDLE;
        endcase
        if (stop_det)
            state_d = S_IDLE;
        else if (start_det && state_q != S_IDLE && state_q != S_HOLD)
            state_d = S_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // bit shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
        end else if (start_det || stop_det || !in_shift) begin
            bit_cnt_q <= '0;
        end else if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            shift_q   <= byte_in[BYTE_W-2:0];
        end
    end

    // outputs: acknowledge pull, register pointer, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            ptr_q     <= '0;
            dat_q     <= '0;
            wr_stb_q  <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_stb_q <= 1'b0;
            if (start_det || stop_det)
                ack_q <= 1'b0;
            else if (in_ack && scl_fall)
                ack_q <= ~ack_q;
            if (state_q == S_REG && scl_rise && bit_last)
                ptr_q <= byte_in[ADDR_W-1:0];
            if (state_q == S_DAT && scl_rise && bit_last)
                dat_q <= byte_in;
            if (commit) begin
                wr_stb_q  <= 1'b1;
                wr_addr_q <= ptr_q;
                wr_data_q <= dat_q;
                ptr_q     <= ptr_q + 1'b1;
            end
        end
    end

    assign sda_pull_o = ack_q;
    assign wr_stb_o   = wr_stb_q;
    assign wr_addr_o  = wr_addr_q;
    assign wr_data_o  = wr_data_q;

    twr_regfile #(.AW(ADDR_W), .DW(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .we_i(wr_stb_q), .waddr_i(wr_addr_q), .wdata_i(wr_data_q),
        .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );

    // ---------------- assertions ----------------
    p_pull_in_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> in_ack);

    p_pull_on_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> !$past(scl_s));

    p_release_on_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ack_q) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

    p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |=> !wr_stb_q);

    p_stb_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |-> $past(state_q) == S_DAT_ACK);

    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state_q == S_IDLE);

    p_start_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && state_q != S_IDLE && state_q != S_HOLD) |=> state_q == S_IDLE);
endmodule

// File: tb/tb_twr_slave.sv
module tb_twr_slave;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_line;
    logic       sda_pull;
    logic [6:0] dev_addr = 7'h3A;
    logic       cont_en = 1'b0;
    logic       wr_stb;
    logic [6:0] wr_addr, rd_addr = '0;
    logic [7:0] wr_data, rd_data;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [14:0] exp_q [$];

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    twr_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .dev_addr_i(dev_addr), .cont_en_i(cont_en),
        .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
        end
        wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic pre, got, rel;
        send_bits(b, 8);
        sda_m = 1'b1; wq();
        pre = sda_pull;
        scl_m = 1'b1; wq();
        got = ~sda_line;
        wq(); scl_m = 1'b0; wq();
        rel = sda_pull;
        check(got == exp_ack, req, got, exp_ack);
        if (exp_ack) begin
            check(pre == 1'b1, "R11 pull before clock high", pre, 1);
            check(rel == 1'b0, "R11 release after 9th fall", rel, 0);
        end
    endtask

    task automatic expect_wr(input logic [6:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    task automatic read_chk(input logic [6:0] a, input logic [7:0] d, input string req);
        @(negedge clk); rd_addr = a; @(negedge clk);
        check(rd_data == d, req, rd_data, d);
    endtask

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6/R7 unexpected write", {wr_addr, wr_data}, 0);
            end else begin
                logic [14:0] e;
                e = exp_q.pop_front();
                check({wr_addr, wr_data} == e, "R6 write addr/data", {wr_addr, wr_data}, e);
            end
            @(negedge clk);
            check(wr_stb == 1'b0, "R6 strobe one cycle", wr_stb, 0);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sda_pull == 1'b0, "R1 no pull", sda_pull, 0);
        check(wr_stb == 1'b0, "R1 no strobe", wr_stb, 0);
        read_chk(7'h00, 8'h00, "R1 regfile clear");
        read_chk(7'h7F, 8'h00, "R1 regfile clear");

        // R2 R5 R6: single write, register byte bit 7 ignored
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R2 address ack");
        send_byte(8'h85, 1, "R5 register ack");
        expect_wr(7'h05, 8'hC3);
        send_byte(8'hC3, 1, "R6 data ack");
        bus_stop();
        read_chk(7'h05, 8'hC3, "R6 regfile holds data");
        read_chk(7'h05 | 7'h00, 8'hC3, "R5 bit7 ignored");

        // R7: second byte without continuous mode
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R2 address ack");
        send_byte(8'h10, 1, "R5 register ack");
        expect_wr(7'h10, 8'h11);
        send_byte(8'h11, 1, "R6 data ack");
        send_byte(8'h22, 0, "R7 extra byte not acked");
        bus_stop();
        read_chk(7'h11, 8'h00, "R7 no write to next register");

        // R8: continuous mode with wrap
        cont_en = 1'b1;
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R2 address ack");
        send_byte(8'h7E, 1, "R5 register ack");
        expect_wr(7'h7E, 8'hAA);
        send_byte(8'hAA, 1, "R8 data ack");
        expect_wr(7'h7F, 8'hBB);
        send_byte(8'hBB, 1, "R8 data ack");
        expect_wr(7'h00, 8'hCC);
        send_byte(8'hCC, 1, "R8 data ack after wrap");
        bus_stop();
        cont_en = 1'b0;
        read_chk(7'h7F, 8'hBB, "R8 incremented address");
        read_chk(7'h00, 8'hCC, "R8 wrap to 0");

        // R3: address mismatch
        bus_start();
        send_byte({7'h3B, 1'b0}, 0, "R3 mismatch not acked");
        send_byte(8'h20, 0, "R3 later byte not acked");
        send_byte(8'h55, 0, "R3 later byte not acked");
        bus_stop();
        read_chk(7'h20, 8'h00, "R3 nothing written");

        // R4: read request refused
        bus_start();
        send_byte({7'h3A, 1'b1}, 0, "R4 read not acked");
        send_byte(8'h21, 0, "R4 idle after read");
        bus_stop();
        read_chk(7'h21, 8'h00, "R4 nothing written");

        // R9: stop inside a data byte
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R2 address ack");
        send_byte(8'h30, 1, "R5 register ack");
        send_bits(8'h99, 5);
        bus_stop();
        read_chk(7'h30, 8'h00, "R9 partial byte dropped");
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R9 recovers after stop");
        send_byte(8'h31, 1, "R5 register ack");
        expect_wr(7'h31, 8'h44);
        send_byte(8'h44, 1, "R6 data ack");
        bus_stop();
        read_chk(7'h31, 8'h44, "R9 next transaction written");

        // R10: start inside a data byte
        bus_start();
        send_byte({7'h3A, 1'b0}, 1, "R2 address ack");
        send_byte(8'h40, 1, "R5 register ack");
        send_bits(8'h77, 3);
        bus_start();
        send_byte({7'h3A, 1'b0}, 0, "R10 idle after misplaced start");
        send_byte(8'h40, 0, "R10 not acked");
        send_byte(8'h66, 0, "R10 not acked");
        bus_stop();
        read_chk(7'h40, 8'h00, "R10 nothing written");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule